// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block gathers 32 interrupt sources into one level-sensitive request line for a parent interrupt controller. A rising edge on a source input latches a pending bit, which stays set until software acknowledges it. A per-source mask word blocks pending bits from reaching the output. A mask bit of 1 disables its source, and every source starts disabled after reset.

Software reaches the block through a plain 32-bit register port with a write strobe, a byte address and write data. Reads are combinational on the address. The pending word and the mask word each have one read view and two write-only views: one sets bits and one clears bits. A bit written as 1 acts and a bit written as 0 leaves its bit alone, so software never needs read-modify-write. Software can also raise pending bits itself, which lets it inject interrupts. The mask can be read back, saved and later restored through its set and clear views.

Address map (byte offsets): 0x00 pending read, 0x04 pending set, 0x08 pending clear, 0x0C mask read, 0x10 mask set, 0x14 mask clear.

Top module: `irq_l2_agg`

## Requirements
- R1: During and right after reset the pending word reads 0, the mask word reads 0xFFFFFFFF, and `irq_o` is 0.
- R2: When source input bit i is 0 in one clock and 1 in the next, pending bit i is 1 after that clock edge. It stays 1 after the input returns to 0.
- R3: A write to 0x08 clears each pending bit whose data bit is 1. Pending bits whose data bit is 0 keep their value.
- R4: A write to 0x04 sets to 1 each pending bit whose data bit is 1. Other pending bits keep their value.
- R5: A write to 0x10 sets mask bits (disables those sources) and a write to 0x14 clears mask bits (enables those sources). Bits written as 0 keep their value. No other access changes the mask.
- R6: `irq_o` is a register. After each clock edge it equals the OR over all bits of (pending AND NOT mask), taken from the values held before that edge. It therefore follows a pending or mask change one clock later.
- R7: If a source rising edge and a pending-clear write with a 1 hit the same bit in the same clock, the bit ends up 1.
- R8: A read of 0x00 returns the pending word and a read of 0x0C returns the mask word. Reads of 0x04, 0x08, 0x10 and 0x14, of any other offset, and of any offset not a multiple of 4 return 0. Writes to an unmapped or misaligned offset change nothing.
- R9: A source held at 1 does not set its pending bit again after software clears it. Only a new 0-to-1 transition sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_i | input | 32 | Interrupt source inputs, one per bit |
| reg_wr_i | input | 1 | Register write strobe for this cycle |
| reg_addr_i | input | 5 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` (combinational) |
| irq_o | output | 1 | Registered request line to the parent controller |

## Verification
The assertions check on every cycle the following points. A detected edge always lands in the pending word, even when a clear of that same bit arrives together with it. Set and clear writes act on exactly the bits written as 1. The mask moves only on its own two offsets. The output equals the masked OR of the previous cycle. Unmapped reads return zero. The scenarios cover what needs a history. Latched bits must outlive the source pulse. A held-high source must stay quiet after acknowledgement. A mask must be saved and restored. Writes to unmapped or misaligned offsets must leave both words intact, and this is observed by reading them back.

// File: rtl/irq_l2_pkg.sv
package irq_l2_pkg;

  localparam int unsigned NSRC = 32;

  typedef logic [NSRC-1:0] irq_vec_t;

  // Word index of each register (byte offset divided by four)
  localparam int unsigned IDX_ST_RD  = 0;
  localparam int unsigned IDX_ST_SET = 1;
  localparam int unsigned IDX_ST_CLR = 2;
  localparam int unsigned IDX_MK_RD  = 3;
  localparam int unsigned IDX_MK_SET = 4;
  localparam int unsigned IDX_MK_CLR = 5;
  localparam int unsigned NUM_IDX    = 6;

  typedef struct packed {
    logic st_set;
    logic st_clr;
    logic mk_set;
    logic mk_clr;
  } wr_strobe_t;

  typedef enum logic [1:0] {
    RSEL_ZERO = 2'd0,
    RSEL_STAT = 2'd1,
    RSEL_MASK = 2'd2
  } rd_sel_e;

  // Hardware edges win over the software clear
  function automatic irq_vec_t f_status_next(input irq_vec_t cur,
                                             input irq_vec_t sw_set,
                                             input irq_vec_t sw_clr,
                                             input irq_vec_t hw_rise);
    return (cur & ~sw_clr) | sw_set | hw_rise;
  endfunction

  function automatic irq_vec_t f_mask_next(input irq_vec_t cur,
                                           input irq_vec_t dis,
                                           input irq_vec_t ena);
    return (cur | dis) & ~ena;
  endfunction

  function automatic logic f_any_live(input irq_vec_t stat,
                                      input irq_vec_t mask);
    return |(stat & ~mask);
  endfunction

endpackage

// File: rtl/irq_l2_decode.sv
module irq_l2_decode
  import irq_l2_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output wr_strobe_t        strobe_o,
  output rd_sel_e           rsel_o
);

  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned_w;
  logic [IDX_W-1:0] idx_w;
  logic [NUM_IDX-1:0] hit_w;

  assign aligned_w = (addr_i[1:0] == 2'b00);
  assign idx_w     = addr_i[ADDR_W-1:2];

  for (genvar k = 0; k < NUM_IDX; k++) begin : g_hit
    assign hit_w[k] = aligned_w && (idx_w == IDX_W'(k));
  end

  assign strobe_o.st_set = wr_i && hit_w[IDX_ST_SET];
  assign strobe_o.st_clr = wr_i && hit_w[IDX_ST_CLR];
  assign strobe_o.mk_set = wr_i && hit_w[IDX_MK_SET];
  assign strobe_o.mk_clr = wr_i && hit_w[IDX_MK_CLR];

  always_comb begin
    rsel_o = RSEL_ZERO;
    if (hit_w[IDX_ST_RD]) rsel_o = RSEL_STAT;
    if (hit_w[IDX_MK_RD]) rsel_o = RSEL_MASK;
  end

endmodule

// File: rtl/irq_l2_edge.sv
module irq_l2_edge
  import irq_l2_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  irq_vec_t src_i,
  output irq_vec_t rise_o
);

  for (genvar b = 0; b < NSRC; b++) begin : g_cell
    logic prev_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) prev_q <= 1'b0;
      else         prev_q <= src_i[b];
    end
    assign rise_o[b] = src_i[b] & ~prev_q;
  end

endmodule

// File: rtl/irq_l2_bank.sv
module irq_l2_bank
  import irq_l2_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  wr_strobe_t strobe_i,
  input  rd_sel_e    rsel_i,
  input  irq_vec_t   wdata_i,
  input  irq_vec_t   rise_i,
  output irq_vec_t   status_o,
  output irq_vec_t   mask_o,
  output irq_vec_t   rdata_o
);

  irq_vec_t status_q, mask_q;
  irq_vec_t sw_set_w, sw_clr_w, mk_dis_w, mk_ena_w;

  assign sw_set_w = strobe_i.st_set ? wdata_i : '0;
  assign sw_clr_w = strobe_i.st_clr ? wdata_i : '0;
  assign mk_dis_w = strobe_i.mk_set ? wdata_i : '0;
  assign mk_ena_w = strobe_i.mk_clr ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '1;
    end else begin
      status_q <= f_status_next(status_q, sw_set_w, sw_clr_w, rise_i);
      mask_q   <= f_mask_next(mask_q, mk_dis_w, mk_ena_w);
    end
  end

  always_comb begin
    unique case (rsel_i)
      RSEL_STAT: rdata_o = status_q;
      RSEL_MASK: rdata_o = mask_q;
      default:   rdata_o = '0;
    endcase
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;

endmodule

// File: rtl/irq_l2_agg.sv
module irq_l2_agg
  import irq_l2_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [NSRC-1:0]   reg_wdata_i,
  output logic [NSRC-1:0]   reg_rdata_o,
  output logic              irq_o
);

  wr_strobe_t strobe_w;
  rd_sel_e    rsel_w;
  irq_vec_t   rise_w;
  irq_vec_t   status_w;
  irq_vec_t   mask_w;
  logic       irq_q;

  irq_l2_decode #(.ADDR_W(ADDR_W)) u_dec (
    .wr_i     (reg_wr_i),
    .addr_i   (reg_addr_i),
    .strobe_o (strobe_w),
    .rsel_o   (rsel_w)
  );

  irq_l2_edge u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .src_i  (src_i),
    .rise_o (rise_w)
  );

  irq_l2_bank u_bank (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .strobe_i (strobe_w),
    .rsel_i   (rsel_w),
    .wdata_i  (reg_wdata_i),
    .rise_i   (rise_w),
    .status_o (status_w),
    .mask_o   (mask_w),
    .rdata_o  (reg_rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= f_any_live(status_w, mask_w);
  end

  assign irq_o = irq_q;

endmodule

// File: rtl/irq_l2_agg_chk.sv
module irq_l2_agg_chk
  import irq_l2_pkg::*;
#(
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_i,
  input logic [ADDR_W-1:0] addr_i,
  input irq_vec_t          wdata_i,
  input irq_vec_t          rdata_i,
  input irq_vec_t          rise_i,
  input irq_vec_t          status_i,
  input irq_vec_t          mask_i,
  input logic              irq_i
);

  localparam logic [ADDR_W-1:0] A_ST_RD  = ADDR_W'(IDX_ST_RD  * 4);
  localparam logic [ADDR_W-1:0] A_ST_SET = ADDR_W'(IDX_ST_SET * 4);
  localparam logic [ADDR_W-1:0] A_ST_CLR = ADDR_W'(IDX_ST_CLR * 4);
  localparam logic [ADDR_W-1:0] A_MK_RD  = ADDR_W'(IDX_MK_RD  * 4);
  localparam logic [ADDR_W-1:0] A_MK_SET = ADDR_W'(IDX_MK_SET * 4);
  localparam logic [ADDR_W-1:0] A_MK_CLR = ADDR_W'(IDX_MK_CLR * 4);

  logic armed_q;
  always_ff @(posedge clk_i) armed_q <= 1'b1;

  always @(negedge clk_i) begin
    if (armed_q === 1'b1 && !rst_ni) begin
      p_reset_vals_r1: assert (status_i == '0 && mask_i == '1 && !irq_i)
        else $error("reset state wrong");
    end
  end

  p_rise_latch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_i != '0) |=> ((status_i & $past(rise_i)) == $past(rise_i)));

  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && addr_i == A_ST_CLR) |=> ((status_i & $past(status_i)) == $past(status_i)));

  p_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ST_CLR) |=> ((status_i & $past(wdata_i) & ~$past(rise_i)) == '0));

  p_force_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ST_SET) |=> ((status_i & $past(wdata_i)) == $past(wdata_i)));

  p_mask_dis_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MK_SET) |=>
      (mask_i == ($past(mask_i) | $past(wdata_i))));

  p_mask_ena_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_MK_CLR) |=>
      (mask_i == ($past(mask_i) & ~$past(wdata_i))));

  p_mask_still_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_i && (addr_i == A_MK_SET || addr_i == A_MK_CLR)) |=> $stable(mask_i));

  p_out_lag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_i == (($past(status_i) & ~$past(mask_i)) != '0)));

  p_set_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && addr_i == A_ST_CLR && (rise_i & wdata_i) != '0) |=>
      ((status_i & $past(rise_i & wdata_i)) == $past(rise_i & wdata_i)));

  p_rd_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != A_ST_RD && addr_i != A_MK_RD) |-> (rdata_i == '0));

  p_rd_view_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MK_RD) |-> (rdata_i == mask_i));

  logic unused_w;
  assign unused_w = &{1'b0, A_ST_SET};

endmodule

bind irq_l2_agg irq_l2_agg_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .wr_i     (reg_wr_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .rdata_i  (reg_rdata_o),
  .rise_i   (rise_w),
  .status_i (status_w),
  .mask_i   (mask_w),
  .irq_i    (irq_o)
);

// File: tb/irq_l2_agg_tb_top.sv
module irq_l2_agg_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src = '0;
  logic        wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] m_pend, m_msk, m_prev;
  logic        m_irq;

  always #2 clk = ~clk;

  irq_l2_agg dut_i (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pend <= 32'h0; m_msk <= 32'hFFFF_FFFF; m_prev <= 32'h0; m_irq <= 1'b0;
    end else begin
      logic [31:0] np, nm;
      int live;
      live = 0;
      for (int i = 0; i < 32; i++) if (m_pend[i] && !m_msk[i]) live++;
      m_irq <= (live > 0);
      for (int i = 0; i < 32; i++) begin
        np[i] = m_pend[i];
        nm[i] = m_msk[i];
        if (wr && addr == 5'h08 && wdata[i]) np[i] = 1'b0;
        if (wr && addr == 5'h04 && wdata[i]) np[i] = 1'b1;
        if (src[i] && !m_prev[i])            np[i] = 1'b1;
        if (wr && addr == 5'h10 && wdata[i]) nm[i] = 1'b1;
        if (wr && addr == 5'h14 && wdata[i]) nm[i] = 1'b0;
      end
      m_pend <= np; m_msk <= nm; m_prev <= src;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Output compared with the model on every clock
  always @(negedge clk) begin
    if (rst_n && !done) check("R6 per-cycle irq", {31'b0, irq}, {31'b0, m_irq});
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles == 20000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<20000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic cyc(input logic [31:0] s, input logic w, input logic [4:0] a,
                     input logic [31:0] d);
    src = s; wr = w; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string tag);
    wr = 1'b0; addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rd(5'h00, 32'h0, "R1 pending at reset");
    rd(5'h0C, 32'hFFFF_FFFF, "R1 mask at reset");
    check("R1 irq at reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(5'h00, 32'h0, "R1 pending after reset");

    // R2: pulse on source 3
    cyc(32'h8, 0, 5'h00, 0);
    cyc(32'h0, 0, 5'h00, 0);
    rd(5'h00, 32'h8, "R2 pulse latched");
    check("R6 masked source quiet", {31'b0, irq}, 32'h0);

    // R5 / R6: unmask source 3
    cyc(32'h0, 1, 5'h14, 32'h8);
    rd(5'h0C, 32'hFFFF_FFF7, "R5 mask clear");
    check("R6 one-cycle lag", {31'b0, irq}, 32'h0);
    cyc(32'h0, 0, 5'h00, 0);
    check("R6 irq raised", {31'b0, irq}, 32'h1);

    // R3: acknowledge
    cyc(32'h0, 1, 5'h08, 32'h8);
    rd(5'h00, 32'h0, "R3 clear");
    cyc(32'h0, 0, 5'h00, 0);
    check("R6 irq dropped", {31'b0, irq}, 32'h0);

    // R4: software injection, then partial clear
    cyc(32'h0, 1, 5'h04, 32'h8000_0031);
    rd(5'h00, 32'h8000_0031, "R4 software set");
    cyc(32'h0, 1, 5'h08, 32'h0000_0011);
    rd(5'h00, 32'h8000_0020, "R3 zeros untouched");

    // R5: mask set/clear and save/restore
    cyc(32'h0, 1, 5'h10, 32'h8);
    rd(5'h0C, 32'hFFFF_FFFF, "R5 mask set");
    cyc(32'h0, 1, 5'h14, 32'h20);
    rd(5'h0C, 32'hFFFF_FFDF, "R5 mask clear bit5");
    cyc(32'h0, 0, 5'h00, 0);
    check("R6 bit5 live", {31'b0, irq}, 32'h1);
    cyc(32'h0, 1, 5'h10, 32'hFFFF_FFFF);
    cyc(32'h0, 1, 5'h14, ~32'hFFFF_FFDF);
    rd(5'h0C, 32'hFFFF_FFDF, "R5 mask restored");

    // R7: rising edge and clear on bit 7 in the same clock
    cyc(32'h80, 1, 5'h08, 32'h80);
    rd(5'h00, 32'h8000_00A0, "R7 set beats clear");
    cyc(32'h0, 1, 5'h08, 32'h80);

    // R9: held source is not re-latched
    cyc(32'h200, 0, 5'h00, 0);
    rd(5'h00, 32'h8000_0220, "R9 first edge");
    cyc(32'h200, 1, 5'h08, 32'h200);
    cyc(32'h200, 0, 5'h00, 0);
    cyc(32'h200, 0, 5'h00, 0);
    rd(5'h00, 32'h8000_0020, "R9 held high stays clear");
    cyc(32'h0, 0, 5'h00, 0);

    // R8: write-only and unmapped views
    rd(5'h04, 32'h0, "R8 read of set view");
    rd(5'h08, 32'h0, "R8 read of clear view");
    rd(5'h10, 32'h0, "R8 read of mask set view");
    rd(5'h14, 32'h0, "R8 read of mask clear view");
    rd(5'h18, 32'h0, "R8 unmapped read");
    rd(5'h02, 32'h0, "R8 misaligned read");
    cyc(32'h0, 1, 5'h18, 32'hFFFF_FFFF);
    cyc(32'h0, 1, 5'h05, 32'hFFFF_FFFF);
    cyc(32'h0, 1, 5'h12, 32'hFFFF_FFFF);
    rd(5'h00, 32'h8000_0020, "R8 pending untouched");
    rd(5'h0C, 32'hFFFF_FFDF, "R8 mask untouched");

    // Mixed patterns against the model
    begin
      logic [31:0] lf;
      lf = 32'hACE1_1234;
      for (int n = 0; n < 60; n++) begin
        logic [4:0] a;
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        a = {lf[7:5], 2'b00};
        cyc(lf ^ {lf[15:0], lf[31:16]}, lf[9], a, {lf[0 +: 16], lf[16 +: 16]});
        rd(5'h00, m_pend, "R2 R3 R4 mixed pending");
        rd(5'h0C, m_msk, "R5 mixed mask");
      end
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule